// File: doc/BRIEF.md
# Halt and Wakeup Power Controller

This block sits beside a small 8-bit processor core and owns its deepest power-save state. Software asks for halt by writing a control flag. While the core is halted, every core clock and timer is gated off and all core state is held. The controller runs from the oscillator clock, which never stops. It watches three wake causes: a multi-bit wakeup port, a rising edge on a dedicated wake pin, and the active-low reset.

On a wake from the port or the pin, the core continues from where it halted. On a reset wake, the core restarts from program address zero. Before clocks return, the controller can hold the core for a fixed oscillator settling period. The period is a 256-step count, and each step is one instruction cycle of nine oscillator clocks. A crystal source always gets this delay. An R/C source gets it only when a configuration bit asks for it. A strap can remove halt entirely. Each state change takes exactly one oscillator clock.

Top module: `halt_wake_ctrl`

## Requirements
- R1: While `rst_n` is low, `pwr_state` is 3 (RESET), `core_clk_en` is 0, `restart_pc0` is 1 and `clkdly` is 0. One `clk_osc` edge after release, the state becomes 0 (RUN) when no delay applies, or 2 (STABILIZING) when `xtal_sel`=1.
- R2: In RUN, a cycle with `ctl_wr`=1 and `ctl_halt`=1 moves the state to 1 (HALT) at the next edge. In HALT, `halt_flag` is 1, `core_clk_en` is 0 and `wdog_inhibit` is 1.
- R3: With `halt_disable`=1, a halt write leaves the state in RUN and `halt_flag` at 0.
- R4: In HALT, either of two events wakes the core: any bit of `wake_port` at 1, or a 0-to-1 change of `wake_pin`. Each input passes a two-flop synchronizer, so the state leaves HALT on the third rising edge after the input changes. A `wake_pin` held steadily high does not wake the core.
- R5: With `xtal_sel`=1 (crystal), `wake_pin` edges are ignored and the core stays in HALT.
- R6: With `xtal_sel`=0 and `clkdly`=0, a wake goes from HALT straight to RUN.
- R7: With `xtal_sel`=1 or `clkdly`=1, a wake goes to STABILIZING. The core stays there for exactly 256×9 = 2304 oscillator cycles with `core_clk_en` at 0, then enters RUN. The timer starts again from zero on every wake.
- R8: `restart_pc0` is 0 after a port or pin wake. After a reset it is 1 until the state reaches RUN.
- R9: A halt write in a cycle where a synchronized wake cause is active leaves the state in RUN.
- R10: `wdog_out_n` is 0 exactly when the state is HALT and `clkmon_en`=1. Otherwise it is 1.
- R11: `clkdly` takes `ctl_clkdly` on a `ctl_wr` in RUN. Reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Active-low reset; also a wake cause |
| xtal_sel | input | 1 | Clock source strap: 1 = crystal, 0 = R/C |
| halt_disable | input | 1 | Strap that blocks halt entry |
| clkmon_en | input | 1 | Clock monitor enabled |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_halt | input | 1 | Halt flag write data |
| ctl_clkdly | input | 1 | Delay-select bit write data |
| wake_port | input | WAKE_W | Multi-input wakeup lines, active high |
| wake_pin | input | 1 | Dedicated wake pin, rising edge |
| core_clk_en | output | 1 | Core clock enable |
| wdog_inhibit | output | 1 | Watchdog hold while core clocks are off |
| wdog_out_n | output | 1 | Watchdog output, driven low by the clock monitor in halt |
| restart_pc0 | output | 1 | Core restarts from address zero |
| halt_flag | output | 1 | Halt flag readback |
| clkdly | output | 1 | Delay-select bit readback |
| pwr_state | output | 2 | 0 RUN, 1 HALT, 2 STABILIZING, 3 RESET |

## Verification
The bench times the settling window to the exact cycle. A design with an off-by-one prescaler or counter, or one that kept the timer value from an earlier wake, would give a count other than 2304. It checks that a crystal source ignores pin edges and that a pin held high never wakes the core; a design that sampled the pin level or skipped the source check would wake wrongly. It issues a halt write while a wake cause is already active; a design that gave halt priority would halt with the wake cause already spent. It also checks that a reset wake keeps the restart-at-zero indication through settling and clears the delay bit, and that a port wake never raises that indication.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_STAB = 2'd2,
    ST_RST  = 2'd3
  } hwc_state_e;
endpackage

// File: rtl/hwc_sync.sv
// Multi-stage synchronizer into the oscillator domain.
module hwc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hwc_stab_timer.sv
// Settling timer: a prescaler divides the oscillator by PRESCALE into
// instruction ticks, and DLY_COUNT ticks make up the window.
module hwc_stab_timer #(
  parameter int DLY_COUNT = 256,
  parameter int PRESCALE  = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick,
  output logic done
);
  localparam int PS_W  = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int CNT_W = (DLY_COUNT > 1) ? $clog2(DLY_COUNT) : 1;

  logic [PS_W-1:0]  ps_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic ps_last(input logic [PS_W-1:0] p);
    return p == PS_W'(PRESCALE - 1);
  endfunction

  function automatic logic [PS_W-1:0] ps_next(input logic [PS_W-1:0] p);
    return ps_last(p) ? '0 : p + 1'b1;
  endfunction

  function automatic logic cnt_last(input logic [CNT_W-1:0] c);
    return c == CNT_W'(DLY_COUNT - 1);
  endfunction

  assign tick = run && ps_last(ps_q);
  assign done = tick && cnt_last(cnt_q);

  // The timer is held at zero outside the window, so every wake starts it fresh.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q  <= '0;
      cnt_q <= '0;
    end else if (!run) begin
      ps_q  <= '0;
      cnt_q <= '0;
    end else begin
      ps_q <= ps_next(ps_q);
      if (tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ps_q <= PS_W'(PRESCALE - 1)); // R7
  AST_COUNT_HOLDS_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> (cnt_q == $past(cnt_q))); // R7
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
  import hwc_pkg::*;
#(
  parameter int WAKE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DLY_COUNT   = 256,
  parameter int PRESCALE    = 9
) (
  input  logic              clk_osc,
  input  logic              rst_n,
  input  logic              xtal_sel,
  input  logic              halt_disable,
  input  logic              clkmon_en,
  input  logic              ctl_wr,
  input  logic              ctl_halt,
  input  logic              ctl_clkdly,
  input  logic [WAKE_W-1:0] wake_port,
  input  logic              wake_pin,
  output logic              core_clk_en,
  output logic              wdog_inhibit,
  output logic              wdog_out_n,
  output logic              restart_pc0,
  output logic              halt_flag,
  output logic              clkdly,
  output logic [1:0]        pwr_state
);
  hwc_state_e        state_q, state_d;
  logic [WAKE_W-1:0] port_s;
  logic              pin_s, pin_d;
  logic              port_wake, pin_rise, pin_wake, wake_evt;
  logic              halt_req, need_delay;
  logic              stab_run, stab_tick, stab_done;
  logic              clkdly_q, from_rst_q;

  function automatic hwc_state_e wake_target(input logic delay);
    return delay ? ST_STAB : ST_RUN;
  endfunction

  hwc_sync #(.W(WAKE_W), .STAGES(SYNC_STAGES)) u_port_sync (
    .clk(clk_osc), .rst_n(rst_n), .d(wake_port), .q(port_s));

  hwc_sync #(.W(1), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk_osc), .rst_n(rst_n), .d(wake_pin), .q(pin_s));

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) pin_d <= 1'b0;
    else        pin_d <= pin_s;
  end

  // Named wake events, brought out for the checks below.
  assign port_wake  = |port_s;
  assign pin_rise   = pin_s && !pin_d;
  assign pin_wake   = pin_rise && !xtal_sel;
  assign wake_evt   = port_wake || pin_wake;
  assign halt_req   = ctl_wr && ctl_halt && !halt_disable && (state_q == ST_RUN);
  assign need_delay = xtal_sel || clkdly_q;
  assign stab_run   = (state_q == ST_STAB);

  hwc_stab_timer #(.DLY_COUNT(DLY_COUNT), .PRESCALE(PRESCALE)) u_timer (
    .clk(clk_osc), .rst_n(rst_n), .run(stab_run), .tick(stab_tick), .done(stab_done));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (halt_req && !wake_evt) state_d = ST_HALT;
      ST_HALT: if (wake_evt) state_d = wake_target(need_delay);
      ST_STAB: if (stab_done) state_d = ST_RUN;
      ST_RST:  state_d = wake_target(need_delay);
      default: state_d = ST_RST;
    endcase
  end

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_RST;
      clkdly_q   <= 1'b0;
      from_rst_q <= 1'b1;
    end else begin
      state_q <= state_d;
      if (ctl_wr && state_q == ST_RUN) clkdly_q <= ctl_clkdly;
      if (state_d == ST_RUN) from_rst_q <= 1'b0;
    end
  end

  assign core_clk_en  = (state_q == ST_RUN);
  assign wdog_inhibit = (state_q != ST_RUN);
  assign wdog_out_n   = !(clkmon_en && state_q == ST_HALT);
  assign restart_pc0  = from_rst_q;
  assign halt_flag    = (state_q == ST_HALT);
  assign clkdly       = clkdly_q;
  assign pwr_state    = state_q;

  AST_HALT_MASKED: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (state_q == ST_RUN && ctl_wr && ctl_halt && halt_disable) |=> state_q != ST_HALT); // R3
  AST_HALT_ENTRY: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (state_q == ST_RUN && ctl_wr && ctl_halt && !halt_disable && !wake_evt) |=> state_q == ST_HALT); // R2
  AST_HALT_NEEDS_WAKE: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (state_q == ST_HALT && !wake_evt) |=> state_q == ST_HALT); // R4
  AST_XTAL_PIN_IGNORED: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (state_q == ST_HALT && xtal_sel && !port_wake) |=> state_q == ST_HALT); // R5
  AST_NO_DELAY_DIRECT: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (state_q == ST_HALT && wake_evt && !xtal_sel && !clkdly_q) |=> state_q == ST_RUN); // R6
  AST_STAB_HOLD: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (state_q == ST_STAB && !stab_done) |=> state_q == ST_STAB); // R7
  AST_RESUME_IN_PLACE: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (state_q == ST_HALT) |-> !restart_pc0); // R8
  AST_WAKE_WINS: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (state_q == ST_RUN && wake_evt) |=> state_q != ST_HALT); // R9
endmodule

// File: tb/halt_wake_ctrl_test.sv
module halt_wake_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int WAKE_W     = 8;
  localparam int STAB_LEN   = 256 * 9;
  localparam int WD_CYCLES  = 100000;

  logic clk = 1'b0;
  logic rst_n, xtal_sel, halt_disable, clkmon_en, ctl_wr, ctl_halt, ctl_clkdly, wake_pin;
  logic [WAKE_W-1:0] wake_port;
  logic core_clk_en, wdog_inhibit, wdog_out_n, restart_pc0, halt_flag, clkdly;
  logic [1:0] pwr_state;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  halt_wake_ctrl #(.WAKE_W(WAKE_W)) uut (
    .clk_osc(clk), .rst_n(rst_n), .xtal_sel(xtal_sel), .halt_disable(halt_disable),
    .clkmon_en(clkmon_en), .ctl_wr(ctl_wr), .ctl_halt(ctl_halt), .ctl_clkdly(ctl_clkdly),
    .wake_port(wake_port), .wake_pin(wake_pin), .core_clk_en(core_clk_en),
    .wdog_inhibit(wdog_inhibit), .wdog_out_n(wdog_out_n), .restart_pc0(restart_pc0),
    .halt_flag(halt_flag), .clkdly(clkdly), .pwr_state(pwr_state));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ctl_write(input logic h, input logic d);
    ctl_wr = 1'b1; ctl_halt = h; ctl_clkdly = d;
    step(1);
    ctl_wr = 1'b0; ctl_halt = 1'b0; ctl_clkdly = 1'b0;
  endtask

  // Counts the samples spent in STABILIZING; also flags any clock enable seen there.
  task automatic measure_stab(input string req, input logic exp_pc0);
    int n = 0;
    int bad_en = 0;
    int bad_pc = 0;
    while (pwr_state == 2'd2 && n < 5000) begin
      n++;
      if (core_clk_en) bad_en++;
      if (restart_pc0 != exp_pc0) bad_pc++;
      step(1);
    end
    chk(req, "settling window length", n, STAB_LEN);
    chk(req, "clock enable during settling", bad_en, 0);
    chk("R8", "restart_pc0 during settling", bad_pc, 0);
    chk(req, "state after settling", pwr_state, 0);
    chk(req, "clock enable after settling", core_clk_en, 1);
  endtask

  task automatic t_reset_state();
    #1;
    chk("R1", "state in reset", pwr_state, 3);
    chk("R1", "clk_en in reset", core_clk_en, 0);
    chk("R1", "restart_pc0 in reset", restart_pc0, 1);
    chk("R1", "clkdly in reset", clkdly, 0);
    rst_n = 1'b1;
    step(1);
    chk("R1", "state after release", pwr_state, 0);
    chk("R1", "clk_en after release", core_clk_en, 1);
    chk("R8", "restart_pc0 cleared in run", restart_pc0, 0);
    chk("R2", "inhibit low in run", wdog_inhibit, 0);
  endtask

  task automatic t_halt_enter();
    clkmon_en = 1'b1;
    ctl_write(1'b1, 1'b0);
    chk("R2", "state after halt write", pwr_state, 1);
    chk("R2", "halt_flag", halt_flag, 1);
    chk("R2", "clk_en in halt", core_clk_en, 0);
    chk("R2", "inhibit in halt", wdog_inhibit, 1);
    chk("R10", "wdog_out_n with monitor on", wdog_out_n, 0);
    clkmon_en = 1'b0;
    #1;
    chk("R10", "wdog_out_n with monitor off", wdog_out_n, 1);
  endtask

  task automatic t_port_wake(input logic [WAKE_W-1:0] pat);
    ctl_write(1'b1, 1'b0);
    chk("R2", "halted before port wake", pwr_state, 1);
    wake_port = pat;
    step(2);
    chk("R4", "still halted two edges after port wake", pwr_state, 1);
    step(1);
    chk("R6", "run after port wake", pwr_state, 0);
    chk("R8", "resume in place after port wake", restart_pc0, 0);
    clkmon_en = 1'b1;
    #1;
    chk("R10", "wdog_out_n high in run", wdog_out_n, 1);
    clkmon_en = 1'b0;
    wake_port = '0;
    step(3);
  endtask

  task automatic t_pin_wake();
    ctl_write(1'b1, 1'b0);
    wake_pin = 1'b1;
    step(2);
    chk("R4", "still halted two edges after pin edge", pwr_state, 1);
    step(1);
    chk("R4", "run after pin edge", pwr_state, 0);
    chk("R8", "resume in place after pin wake", restart_pc0, 0);
    ctl_write(1'b1, 1'b0);
    step(8);
    chk("R4", "pin held high does not wake", pwr_state, 1);
    wake_pin = 1'b0;
    step(4);
    chk("R4", "pin falling does not wake", pwr_state, 1);
    wake_pin = 1'b1;
    step(3);
    chk("R4", "second pin edge wakes", pwr_state, 0);
    wake_pin = 1'b0;
    step(3);
  endtask

  task automatic t_xtal();
    xtal_sel = 1'b1;
    ctl_write(1'b1, 1'b0);
    wake_pin = 1'b1;
    step(8);
    chk("R5", "pin edge ignored with crystal", pwr_state, 1);
    wake_pin = 1'b0;
    step(3);
    wake_port = 8'h80;
    step(3);
    chk("R7", "crystal wake enters settling", pwr_state, 2);
    wake_port = '0;
    measure_stab("R7", 1'b0);
    xtal_sel = 1'b0;
    step(3);
  endtask

  task automatic t_clkdly();
    ctl_write(1'b0, 1'b1);
    chk("R11", "clkdly written", clkdly, 1);
    ctl_write(1'b1, 1'b1);
    wake_port = 8'h04;
    step(3);
    chk("R7", "R/C wake with clkdly enters settling", pwr_state, 2);
    wake_port = '0;
    measure_stab("R7", 1'b0);
    ctl_write(1'b0, 1'b0);
    chk("R11", "clkdly cleared by write", clkdly, 0);
    step(3);
  endtask

  task automatic t_halt_disable();
    halt_disable = 1'b1;
    ctl_write(1'b1, 1'b0);
    chk("R3", "state with halt disabled", pwr_state, 0);
    chk("R3", "halt_flag with halt disabled", halt_flag, 0);
    step(4);
    chk("R3", "still running later", pwr_state, 0);
    halt_disable = 1'b0;
  endtask

  task automatic t_same_cycle();
    wake_port = 8'h01;
    step(3);
    ctl_write(1'b1, 1'b0);
    chk("R9", "halt write during active wake stays awake", pwr_state, 0);
    chk("R9", "halt_flag stays low", halt_flag, 0);
    wake_port = '0;
    step(3);
  endtask

  task automatic t_reset_wake();
    ctl_write(1'b0, 1'b1);
    xtal_sel = 1'b1;
    ctl_write(1'b1, 1'b1);
    chk("R2", "halted before reset", pwr_state, 1);
    rst_n = 1'b0;
    #1;
    chk("R1", "reset state from halt", pwr_state, 3);
    chk("R8", "restart_pc0 on reset", restart_pc0, 1);
    chk("R11", "clkdly cleared by reset", clkdly, 0);
    step(2);
    rst_n = 1'b1;
    step(1);
    chk("R1", "crystal reset release enters settling", pwr_state, 2);
    measure_stab("R7", 1'b1);
    chk("R8", "restart_pc0 cleared at run", restart_pc0, 0);
    xtal_sel = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; xtal_sel = 1'b0; halt_disable = 1'b0; clkmon_en = 1'b0;
    ctl_wr = 1'b0; ctl_halt = 1'b0; ctl_clkdly = 1'b0; wake_pin = 1'b0; wake_port = '0;
    step(3);
    t_reset_state();
    t_halt_enter();
    t_port_wake(8'h01);
    t_port_wake(8'h5A);
    t_port_wake(8'h80);
    t_pin_wake();
    t_xtal();
    t_clkdly();
    t_halt_disable();
    t_same_cycle();
    t_reset_wake();
    finish_run();
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule